// File: doc/BRIEF.md
# Interrupt Vector Priority Unit

This block chooses which interrupt a small processor core takes and the address it jumps to. It collects a power-on request, three timer flags and eight port lines. When several timer flags are set at the same moment, they map to a dedicated combined vector rather than to the vector of a single timer. The core tells the block when an instruction has finished, and whether that instruction was a taken jump or a return. A request is accepted only at a finished instruction that was not a taken jump or a return.

For each port line the block keeps an enable bit and a pending bit. A pin's two mode bits decide whether a high level, a low level or nothing at all raises its request. A pending request is held until software clears it by writing 0 to the enable bit. The pending bits are visible on an output. The accept strobe and the vector are registered. The vector keeps its value until the next accepted interrupt.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, irq_take is 0, irq_vec is 0x000, all port enables are 0 and port_pend is 0.
- R2: A power-on request wins over every other source, with vector 0x000.
- R3: When all three timer flags are set (tmr_flag = 3'b111) and there is no power-on request, the vector is 0x08F.
- R4: Two timer flags give a pair vector: T2+T3 (3'b110) gives 0x09F, T1+T3 (3'b101) gives 0x0AF, and T1+T2 (3'b011) gives 0x0CF.
- R5: A single timer flag gives its own vector: T3 (3'b100) gives 0x0BF, T2 (3'b010) gives 0x0DF and T1 (3'b001) gives 0x0EF. Any timer flag takes priority over the port requests. In tmr_flag, bit 0 is T1, bit 1 is T2 and bit 2 is T3.
- R6: When only port requests are pending, the vector is 0x0FF.
- R7: Nothing is accepted in a cycle where insn_done is 0.
- R8: Nothing is accepted in a cycle where insn_done and branch_taken are both 1.
- R9: An interrupt accepted at a clock edge shows irq_take = 1 and its vector after that edge, for one cycle. irq_vec changes only when irq_take is 1.
- R10: Port line i takes its mode from port_mode[2i+1:2i]. Modes 2'b00 and 2'b01 never raise a request.
- R11: Mode 2'b10 raises a request while the pin is high. Mode 2'b11 raises a request while the pin is low. The request appears in port_pend one cycle later.
- R12: A line whose enable bit is 0 raises no request. A write with a 0 for that line clears its pending bit. Writing 1 again does not bring back a cleared request; the line only listens to its pin again.
- R13: A pending port request stays set after the pin returns to its quiet level, and after a timer vector or the port vector is taken. It clears only when its enable bit is written to 0.
- R14: port_pend shows the pending bit of each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_done | input | 1 | The current instruction has fully finished |
| branch_taken | input | 1 | The finished instruction was a taken jump or a return |
| por_req | input | 1 | Power-on request |
| tmr_flag | input | 3 | Timer flags: bit 0 is T1, bit 1 is T2, bit 2 is T3 |
| port_pin | input | NUM_PORTS | Port pin levels |
| port_mode | input | 2*NUM_PORTS | Two mode bits per line |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_PORTS | New enable bits |
| irq_take | output | 1 | Interrupt accepted, one cycle per acceptance |
| irq_vec | output | 12 | Vector address of the last accepted interrupt |
| port_pend | output | NUM_PORTS | Pending port requests |

## Verification
The bench builds the block with the default NUM_PORTS of 8. This gives each of the four pin modes at least one line in the directed phase, and leaves enough lines to see a partial clear next to requests that stay pending. A long random phase changes the modes, pin levels, timer flag combinations and enable writes every few cycles. This brings into reach timer and port requests that arrive together, and clears that land at the same edge as new requests.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VEC_W = 12;

    localparam logic [VEC_W-1:0] VEC_POWER = 12'h000;
    localparam logic [VEC_W-1:0] VEC_T123  = 12'h08F;
    localparam logic [VEC_W-1:0] VEC_T23   = 12'h09F;
    localparam logic [VEC_W-1:0] VEC_T13   = 12'h0AF;
    localparam logic [VEC_W-1:0] VEC_T12   = 12'h0CF;
    localparam logic [VEC_W-1:0] VEC_T3    = 12'h0BF;
    localparam logic [VEC_W-1:0] VEC_T2    = 12'h0DF;
    localparam logic [VEC_W-1:0] VEC_T1    = 12'h0EF;
    localparam logic [VEC_W-1:0] VEC_PORT  = 12'h0FF;

    typedef enum logic [1:0] {
        PM_OUT_HIZ = 2'b00,
        PM_OUT_LOW = 2'b01,
        PM_IN_HIGH = 2'b10,
        PM_IN_LOW  = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
    } vec_out_t;
endpackage

// File: rtl/irqv_level_decode.sv
module irqv_level_decode
    import irqv_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0]   pin,
    input  logic [2*NUM_PORTS-1:0] mode,
    output logic [NUM_PORTS-1:0]   active
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_line
        pin_mode_e m;
        assign m = pin_mode_e'(mode[2*i +: 2]);
        always_comb begin
            unique case (m)
                PM_IN_HIGH: active[i] = pin[i];
                PM_IN_LOW:  active[i] = ~pin[i];
                default:    active[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irqv_port_bank.sv
module irqv_port_bank #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_wr,
    input  logic [NUM_PORTS-1:0] en_wdata,
    input  logic [NUM_PORTS-1:0] active,
    output logic [NUM_PORTS-1:0] en_q,
    output logic [NUM_PORTS-1:0] pend_q
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] en;
        logic [NUM_PORTS-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d    = bank_q;
        bank_d.en = en_wr ? en_wdata : bank_q.en;
        // a line listens only while enabled; a zero enable wipes the latch
        bank_d.pend = bank_d.en & (bank_q.pend | (active & bank_q.en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_q   = bank_q.en;
    assign pend_q = bank_q.pend;
endmodule

// File: rtl/irqv_vec_select.sv
module irqv_vec_select
    import irqv_pkg::*;
(
    input  logic             por,
    input  logic [2:0]       tmr,
    input  logic             port_any,
    output logic             any_req,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        any_req = por | (|tmr) | port_any;
        if (por) begin
            vec = VEC_POWER;
        end else begin
            unique case (tmr)
                3'b111:  vec = VEC_T123;
                3'b110:  vec = VEC_T23;
                3'b101:  vec = VEC_T13;
                3'b011:  vec = VEC_T12;
                3'b100:  vec = VEC_T3;
                3'b010:  vec = VEC_T2;
                3'b001:  vec = VEC_T1;
                default: vec = VEC_PORT;
            endcase
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   insn_done,
    input  logic                   branch_taken,
    input  logic                   por_req,
    input  logic [2:0]             tmr_flag,
    input  logic [NUM_PORTS-1:0]   port_pin,
    input  logic [2*NUM_PORTS-1:0] port_mode,
    input  logic                   en_wr,
    input  logic [NUM_PORTS-1:0]   en_wdata,
    output logic                   irq_take,
    output logic [VEC_W-1:0]       irq_vec,
    output logic [NUM_PORTS-1:0]   port_pend
);
    logic [NUM_PORTS-1:0] line_active;
    logic [NUM_PORTS-1:0] en_cur;
    logic [NUM_PORTS-1:0] pend_cur;
    logic                 any_req;
    logic [VEC_W-1:0]     sel_vec;
    logic                 accept;
    vec_out_t             out_d, out_q;

    irqv_level_decode #(.NUM_PORTS(NUM_PORTS)) i_decode (
        .pin    (port_pin),
        .mode   (port_mode),
        .active (line_active)
    );

    irqv_port_bank #(.NUM_PORTS(NUM_PORTS)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .active   (line_active),
        .en_q     (en_cur),
        .pend_q   (pend_cur)
    );

    irqv_vec_select i_select (
        .por      (por_req),
        .tmr      (tmr_flag),
        .port_any (|pend_cur),
        .any_req  (any_req),
        .vec      (sel_vec)
    );

    always_comb begin
        accept     = insn_done & ~branch_taken & any_req;
        out_d      = out_q;
        out_d.take = accept;
        if (accept) begin
            out_d.vec = sel_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_take  = out_q.take;
    assign irq_vec   = out_q.vec;
    assign port_pend = pend_cur;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   insn_done,
    input logic                   branch_taken,
    input logic                   por_req,
    input logic [2*NUM_PORTS-1:0] port_mode,
    input logic                   en_wr,
    input logic [NUM_PORTS-1:0]   en_wdata,
    input logic                   irq_take,
    input logic [VEC_W-1:0]       irq_vec,
    input logic [NUM_PORTS-1:0]   port_pend,
    input logic [NUM_PORTS-1:0]   port_en
);
    logic [NUM_PORTS-1:0] quiet_mode;

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            quiet_mode[i] = ~port_mode[2*i+1];
        end
    end

    AST_POWER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req && insn_done && !branch_taken) |=> (irq_take && irq_vec == VEC_POWER)); // R2

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(insn_done)); // R7

    AST_NO_TAKE_AFTER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !$past(branch_taken)); // R8

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> $stable(irq_vec)); // R9

    AST_QUIET_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_pend & ~$past(port_pend) & $past(quiet_mode)) == '0); // R10

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (port_pend & ~port_en) == '0); // R12

    AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((port_pend & ~$past(en_wdata)) == '0)); // R12
endmodule

bind irq_vector_unit irqv_checker #(.NUM_PORTS(NUM_PORTS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done    (insn_done),
    .branch_taken (branch_taken),
    .por_req      (por_req),
    .port_mode    (port_mode),
    .en_wr        (en_wr),
    .en_wdata     (en_wdata),
    .irq_take     (irq_take),
    .irq_vec      (irq_vec),
    .port_pend    (port_pend),
    .port_en      (en_cur)
);

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
module test_irq_vector_unit;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           insn_done = 1'b0;
    logic           branch_taken = 1'b0;
    logic           por_req = 1'b0;
    logic [2:0]     tmr_flag = '0;
    logic [N-1:0]   port_pin = '0;
    logic [2*N-1:0] port_mode = '0;
    logic           en_wr = 1'b0;
    logic [N-1:0]   en_wdata = '0;
    logic           irq_take;
    logic [11:0]    irq_vec;
    logic [N-1:0]   port_pend;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done_flag = 1'b0;

    // reference model state
    bit         m_take;
    int         m_vec;
    bit [N-1:0] m_en;
    bit [N-1:0] m_pend;

    always #2 clk = ~clk;

    irq_vector_unit #(.NUM_PORTS(N)) i_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .branch_taken(branch_taken),
        .por_req(por_req), .tmr_flag(tmr_flag), .port_pin(port_pin), .port_mode(port_mode),
        .en_wr(en_wr), .en_wdata(en_wdata), .irq_take(irq_take), .irq_vec(irq_vec),
        .port_pend(port_pend)
    );

    function automatic int ref_vector(bit por, bit t1, bit t2, bit t3);
        if (por) return 'h000;
        if (t1 && t2 && t3) return 'h08F;
        if (t2 && t3) return 'h09F;
        if (t1 && t3) return 'h0AF;
        if (t1 && t2) return 'h0CF;
        if (t3) return 'h0BF;
        if (t2) return 'h0DF;
        if (t1) return 'h0EF;
        return 'h0FF;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_take = 0; m_vec = 0; m_en = '0; m_pend = '0;
        end else begin
            bit [N-1:0] req_now;
            bit [N-1:0] next_en;
            bit         ok;
            for (int i = 0; i < N; i++) begin
                int md;
                md = port_mode[2*i +: 2];
                req_now[i] = (md == 2) ? port_pin[i] : (md == 3) ? !port_pin[i] : 1'b0;
            end
            next_en = en_wr ? en_wdata : m_en;
            ok = insn_done && !branch_taken && (por_req || tmr_flag != 0 || m_pend != 0);
            m_take = ok;
            if (ok) m_vec = ref_vector(por_req, tmr_flag[0], tmr_flag[1], tmr_flag[2]);
            m_pend = next_en & (m_pend | (req_now & m_en));
            m_en = next_en;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check(cur_req, "take", irq_take, m_take);
            check(cur_req, "vec", irq_vec, m_vec);
            check(cur_req, "pend", port_pend, m_pend);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary(bit por, bit [2:0] t);
        por_req = por; tmr_flag = t; insn_done = 1;
        tick();
        insn_done = 0; por_req = 0; tmr_flag = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        check("R1", "reset take", irq_take, 0);
        check("R1", "reset vec", irq_vec, 0);
        check("R1", "reset pend", port_pend, 0);
        rst_n = 1;
        tick();

        cur_req = "R3"; boundary(0, 3'b111); check("R3", "vec 111", irq_vec, 'h08F);
        check("R3", "take", irq_take, 1);
        cur_req = "R4"; boundary(0, 3'b110); check("R4", "vec 110", irq_vec, 'h09F);
        boundary(0, 3'b101); check("R4", "vec 101", irq_vec, 'h0AF);
        boundary(0, 3'b011); check("R4", "vec 011", irq_vec, 'h0CF);
        cur_req = "R5"; boundary(0, 3'b100); check("R5", "vec 100", irq_vec, 'h0BF);
        boundary(0, 3'b010); check("R5", "vec 010", irq_vec, 'h0DF);
        boundary(0, 3'b001); check("R5", "vec 001", irq_vec, 'h0EF);
        cur_req = "R2"; boundary(1, 3'b111); check("R2", "power vec", irq_vec, 'h000);
        check("R2", "power take", irq_take, 1);

        cur_req = "R7";
        tmr_flag = 3'b001; insn_done = 0; tick();
        check("R7", "no take without boundary", irq_take, 0);
        cur_req = "R8";
        insn_done = 1; branch_taken = 1; tick();
        check("R8", "no take after jump", irq_take, 0);
        check("R8", "vec held", irq_vec, 'h000);
        cur_req = "R9";
        branch_taken = 0; tick();
        check("R9", "take after edge", irq_take, 1);
        check("R9", "vec", irq_vec, 'h0EF);
        insn_done = 0; tmr_flag = 0; tick();
        check("R9", "strobe one cycle", irq_take, 0);
        check("R9", "vec holds", irq_vec, 'h0EF);

        // lines: 0 hiz, 1 drive low, 2 high-active, 3 low-active, 4..7 high-active
        cur_req = "R10";
        port_mode = {2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b01, 2'b00};
        port_pin = 8'h08;
        en_wr = 1; en_wdata = 8'hFF; tick(); en_wr = 0; tick();
        check("R10", "quiet pins", port_pend, 0);
        cur_req = "R11";
        port_pin = 8'hF7; tick();
        check("R11", "levels to pend", port_pend, 'hFC);
        check("R14", "pend visible", port_pend, 'hFC);
        check("R10", "out modes silent", port_pend & 8'h03, 0);
        cur_req = "R13";
        port_pin = 8'h08; tick();
        check("R13", "latched after quiet", port_pend, 'hFC);
        cur_req = "R6"; boundary(0, 3'b000);
        check("R6", "port vec", irq_vec, 'h0FF);
        cur_req = "R13"; boundary(0, 3'b010);
        check("R5", "timer over port", irq_vec, 'h0DF);
        check("R13", "still pending", port_pend, 'hFC);
        cur_req = "R12";
        en_wr = 1; en_wdata = 8'hFB; tick(); en_wr = 0;
        check("R12", "zero clears line 2", port_pend, 'hF8);
        en_wr = 1; en_wdata = 8'hFF; tick(); en_wr = 0;
        check("R12", "rearm no restore", port_pend, 'hF8);
        port_pin = 8'h0C; tick(); port_pin = 8'h08; tick();
        check("R12", "rearmed line fires", port_pend, 'hFC);
        en_wr = 1; en_wdata = 8'h00; tick(); en_wr = 0;
        port_pin = 8'hF7; tick(2);
        check("R12", "disabled stays clear", port_pend, 0);

        cur_req = "R13";
        for (int k = 0; k < 3000; k++) begin
            if (k % 40 == 0) port_mode = 16'($urandom);
            port_pin = 8'($urandom);
            tmr_flag = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            por_req = ($urandom % 50 == 0);
            insn_done = $urandom % 2;
            branch_taken = ($urandom % 4 == 0);
            en_wr = ($urandom % 8 == 0);
            en_wdata = 8'($urandom);
            tick();
        end
        en_wr = 0; insn_done = 0;
        tick(2);
        finish_run();
    end
endmodule